// File: doc/BRIEF.md
# Pseudo-DMA Data Port

This block is a host-facing data window that lets a CPU move transfer data by plain loads and stores when no DMA engine is available. A command engine arms the port with a buffer select, a start index, a byte length and a flag saying whether a completion action is pending. Once armed, the port raises a data-request line. The host then reads or writes the window one or two bytes at a time. Each access moves bytes between the host bus and one of four internal byte buffers, and shortens the remaining length.

Host writes also count down a shared 24-bit transfer counter. The command engine loads this counter, and the port presents it as three bytes. When the armed length runs out and a completion action is pending, the port drops the request line. It then pulses a done strobe that carries the number of bytes moved. The command engine also has a byte-wide side port into the buffers, so it can fill them before host reads and inspect them after host writes.

Top module: `pdma_port`

## Requirements
- R1: Arming loads the buffer select, the start index (as the current index), the length and the completion flag. The request line reads 1 from the next cycle. Arming does not change the transfer counter.
- R2: Buffer select codes 0, 1, 2 and 3 pick four separate buffers: general, transfer FIFO, command and asynchronous data. Each buffer holds 2^AW bytes, and the index wraps inside its buffer. The engine side port reaches byte `addr` of buffer `sel`, and its read data is combinational.
- R3: A host write changes nothing when the transfer counter is zero or the remaining length is zero. Buffer contents, the counter and the request line all stay as they were.
- R4: A one-byte write stores `hst_wdata[7:0]` at the current index. A one-byte read returns `{8'h00, byte}` in the same cycle. Either one advances the index by 1 and reduces the length by 1.
- R5: A two-byte write stores `hst_wdata[15:8]` at the current index and `hst_wdata[7:0]` at the next index. A two-byte read returns `{byte[idx], byte[idx+1]}`. Either one reduces the length by 2.
- R6: Each accepted write lowers the transfer counter by the number of bytes moved, stopping at zero. The counter appears as `tc_lo` (bits 7:0), `tc_mid` (bits 15:8) and `tc_hi` (bits 23:16), and reads leave it unchanged.
- R7: A read while the remaining length is zero returns 0 and changes no state.
- R8: When an access brings the length to zero and the completion flag is set, the request line reads 0 from the next cycle. `done` is high for exactly that one cycle, and the flag is cleared. If the flag is clear, the request line stays high and `done` does not fire.
- R9: During the `done` pulse, `done_count` equals the number of bytes moved since arming.
- R10: A two-byte access with one byte remaining moves one byte only. A write stores the high data byte, a read returns `{byte, 8'h00}`, the length stops at zero and the counter drops by 1.
- R11: After reset, `drq` and `done` are 0, the transfer counter is 0 and `done_count` is 0.
- R12: `tc_load` sets the transfer counter to `tc_value` in the next cycle. It takes priority over any decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_valid | input | 1 | Arm strobe from the command engine |
| arm_origin | input | 2 | Buffer select for the armed transfer |
| arm_start | input | AW | Start index within the buffer |
| arm_len | input | AW+1 | Transfer length in bytes |
| arm_notify | input | 1 | Completion action pending for this transfer |
| tc_load | input | 1 | Load the transfer counter |
| tc_value | input | 24 | Value for the transfer counter |
| hst_wr | input | 1 | Host write access |
| hst_rd | input | 1 | Host read access (ignored while hst_wr is high) |
| hst_wide | input | 1 | 1 = two-byte access, 0 = one-byte access |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid in the access cycle |
| eng_we | input | 1 | Engine side-port byte write |
| eng_sel | input | 2 | Engine side-port buffer select |
| eng_addr | input | AW | Engine side-port byte index |
| eng_wdata | input | 8 | Engine side-port write data |
| eng_rdata | output | 8 | Engine side-port read data (combinational) |
| drq | output | 1 | Data-request line |
| tc_lo | output | 8 | Transfer counter bits 7:0 |
| tc_mid | output | 8 | Transfer counter bits 15:8 |
| tc_hi | output | 8 | Transfer counter bits 23:16 |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | AW+1 | Bytes moved, valid with done |

## Verification
Host read data and engine read data are combinational, so the bench samples them in the access cycle itself, 1 ns after it drives the inputs. Every registered effect of an access or an arm becomes visible after the next rising edge: the index, length, counter bytes, request line, `done` and `done_count`. The bench therefore drives on the falling edge and checks these results on the falling edge that follows. It checks `done` again one cycle later to confirm the pulse lasts a single cycle.

// File: rtl/pdma_port.sv
module pdma_port #(
  parameter int AW = 4,
  parameter int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_valid,
  input  logic [1:0]    arm_origin,
  input  logic [AW-1:0] arm_start,
  input  logic [LW-1:0] arm_len,
  input  logic          arm_notify,
  input  logic          tc_load,
  input  logic [23:0]   tc_value,
  input  logic          hst_wr,
  input  logic          hst_rd,
  input  logic          hst_wide,
  input  logic [15:0]   hst_wdata,
  output logic [15:0]   hst_rdata,
  input  logic          eng_we,
  input  logic [1:0]    eng_sel,
  input  logic [AW-1:0] eng_addr,
  input  logic [7:0]    eng_wdata,
  output logic [7:0]    eng_rdata,
  output logic          drq,
  output logic [7:0]    tc_lo,
  output logic [7:0]    tc_mid,
  output logic [7:0]    tc_hi,
  output logic          done,
  output logic [LW-1:0] done_count
);

  localparam int DEPTH = 1 << AW;
  localparam int MW    = AW + 2;

  logic [7:0]    mem [0:4*DEPTH-1];
  logic [1:0]    origin;
  logic [AW-1:0] cur;
  logic [LW-1:0] len;
  logic [LW-1:0] total;
  logic          notify;
  logic [23:0]   tc;

  wire           two    = hst_wide && (len >= LW'(2));
  wire [LW-1:0]  nmove  = two ? LW'(2) : LW'(1);
  wire [AW-1:0]  cur_p1 = cur + AW'(1);
  wire [MW-1:0]  a0     = {origin, cur};
  wire [MW-1:0]  a1     = {origin, cur_p1};
  wire           wr_go  = hst_wr && !arm_valid && (len != '0) && (tc != '0);
  wire           rd_go  = hst_rd && !hst_wr && !arm_valid && (len != '0);
  wire           go     = wr_go || rd_go;
  wire [LW-1:0]  len_nx = len - nmove;
  wire [23:0]    tc_step = 24'(nmove);
  wire [23:0]    tc_nx  = (tc > tc_step) ? (tc - tc_step) : 24'd0;

  assign tc_lo     = tc[7:0];
  assign tc_mid    = tc[15:8];
  assign tc_hi     = tc[23:16];
  assign eng_rdata = mem[{eng_sel, eng_addr}];

  always_comb begin
    hst_rdata = '0;
    if (rd_go)
      hst_rdata = hst_wide ? {mem[a0], (two ? mem[a1] : 8'h00)} : {8'h00, mem[a0]};
  end

  always_ff @(posedge clk) begin
    if (eng_we) mem[{eng_sel, eng_addr}] <= eng_wdata;
    if (wr_go) begin
      mem[a0] <= hst_wide ? hst_wdata[15:8] : hst_wdata[7:0];
      if (two) mem[a1] <= hst_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      origin     <= '0;
      cur        <= '0;
      len        <= '0;
      total      <= '0;
      notify     <= 1'b0;
      drq        <= 1'b0;
      done       <= 1'b0;
      done_count <= '0;
    end else begin
      done <= 1'b0;
      if (arm_valid) begin
        origin <= arm_origin;
        cur    <= arm_start;
        len    <= arm_len;
        total  <= arm_len;
        notify <= arm_notify;
        drq    <= 1'b1;
      end else if (go) begin
        cur <= cur + nmove[AW-1:0];
        len <= len_nx;
        if (len_nx == '0 && notify) begin
          drq        <= 1'b0;
          done       <= 1'b1;
          done_count <= total;
          notify     <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tc <= '0;
    else if (tc_load) tc <= tc_value;
    else if (wr_go)   tc <= tc_nx;
  end

  AST_ARM_RAISES_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    arm_valid |=> drq); // R1
  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && !arm_valid && !tc_load && (tc == '0 || len == '0)) |=> ($stable(tc) && $stable(len) && $stable(cur))); // R3
  AST_TC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !tc_load) |=> (tc < $past(tc))); // R6
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && !hst_wr && len == '0) |-> (hst_rdata == 16'h0000)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_DRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !drq); // R8
  AST_LEN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (len < $past(len))); // R10
  AST_TC_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tc_load |=> ({tc_hi, tc_mid, tc_lo} == $past(tc_value))); // R12

endmodule

// File: tb/pdma_port_tb.sv
module pdma_port_tb;
  localparam int AW = 4;
  localparam int LW = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_valid = 0, arm_notify = 0, tc_load = 0;
  logic [1:0] arm_origin = 0, eng_sel = 0;
  logic [AW-1:0] arm_start = 0, eng_addr = 0;
  logic [LW-1:0] arm_len = 0, done_count;
  logic [23:0] tc_value = 0;
  logic hst_wr = 0, hst_rd = 0, hst_wide = 0, eng_we = 0;
  logic [15:0] hst_wdata = 0, hst_rdata;
  logic [7:0] eng_wdata = 0, eng_rdata, tc_lo, tc_mid, tc_hi;
  logic drq, done;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [0:4*DEPTH-1];
  int m_tc;
  bit finished = 0;

  always #2 clk = ~clk;

  pdma_port #(.AW(AW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .arm_valid(arm_valid), .arm_origin(arm_origin), .arm_start(arm_start),
    .arm_len(arm_len), .arm_notify(arm_notify),
    .tc_load(tc_load), .tc_value(tc_value),
    .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_wide(hst_wide),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .eng_we(eng_we), .eng_sel(eng_sel), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_rdata(eng_rdata),
    .drq(drq), .tc_lo(tc_lo), .tc_mid(tc_mid), .tc_hi(tc_hi),
    .done(done), .done_count(done_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic arm(input int o, input int s, input int l, input bit nt);
    @(negedge clk);
    arm_valid = 1; arm_origin = 2'(o); arm_start = AW'(s); arm_len = LW'(l); arm_notify = nt;
    @(negedge clk);
    arm_valid = 0;
  endtask

  task automatic load_tc(input int v);
    @(negedge clk);
    tc_load = 1; tc_value = 24'(v);
    @(negedge clk);
    tc_load = 0;
  endtask

  task automatic eng_write(input int o, input int a, input logic [7:0] d);
    @(negedge clk);
    eng_we = 1; eng_sel = 2'(o); eng_addr = AW'(a); eng_wdata = d;
    @(negedge clk);
    eng_we = 0;
  endtask

  task automatic eng_read(input int o, input int a, output logic [7:0] d);
    eng_sel = 2'(o); eng_addr = AW'(a);
    #1 d = eng_rdata;
  endtask

  task automatic access(input bit wr, input bit wide, input logic [15:0] wd, output logic [15:0] rd);
    @(negedge clk);
    hst_wr = wr; hst_rd = !wr; hst_wide = wide; hst_wdata = wd;
    #1 rd = hst_rdata;
    @(negedge clk);
    hst_wr = 0; hst_rd = 0;
  endtask

  function automatic int tc_now();
    return int'({tc_hi, tc_mid, tc_lo});
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 drq", 32'(drq), 0);
    check("R11 done", 32'(done), 0);
    check("R11 tc", tc_now(), 0);
    check("R11 done_count", 32'(done_count), 0);

    for (int i = 0; i < 4*DEPTH; i++) begin
      model[i] = 8'(i*29 + 3);
      eng_write(i / DEPTH, i % DEPTH, model[i]);
    end

    // R3: counter zero blocks writes
    load_tc(0);
    arm(1, 2, 3, 1);
    check("R1 drq after arm", 32'(drq), 1);
    check("R1 tc untouched", tc_now(), 0);
    access(1, 0, 16'hBEEF, rd);
    eng_read(1, 2, b);
    check("R3 tc zero byte", 32'(b), 32'(model[DEPTH+2]));
    check("R3 tc zero drq", 32'(drq), 1);
    check("R3 tc zero done", 32'(done), 0);
    // R3: length zero blocks writes
    load_tc(5);
    arm(1, 2, 0, 1);
    access(1, 1, 16'hCAFE, rd);
    eng_read(1, 2, b);
    check("R3 len zero byte", 32'(b), 32'(model[DEPTH+2]));
    eng_read(1, 3, b);
    check("R3 len zero byte2", 32'(b), 32'(model[DEPTH+3]));
    check("R3 len zero tc", tc_now(), 5);

    // R12: load wins over decrement in the same cycle
    arm(2, 0, 2, 0);
    @(negedge clk);
    tc_load = 1; tc_value = 24'h000777; hst_wr = 1; hst_rd = 0; hst_wide = 0; hst_wdata = 16'h0011;
    @(negedge clk);
    tc_load = 0; hst_wr = 0;
    model[2*DEPTH] = 8'h11;
    check("R12 load priority", tc_now(), 32'h777);
    eng_read(2, 0, b);
    check("R4 byte written", 32'(b), 32'h11);

    // R10: two-byte write floors counter at zero
    load_tc(1);
    arm(3, 4, 3, 1);
    access(1, 1, 16'h5A3C, rd);
    model[3*DEPTH+4] = 8'h5A; model[3*DEPTH+5] = 8'h3C;
    check("R10 tc floor", tc_now(), 0);
    check("R10 drq stays", 32'(drq), 1);
    access(1, 0, 16'h00FF, rd);
    eng_read(3, 6, b);
    check("R3 floor then ignored", 32'(b), 32'(model[3*DEPTH+6]));

    // Sweep: write phase then read phase
    for (int o = 0; o < 4; o++) begin
      for (int w = 0; w < 2; w++) begin
        for (int l = 1; l <= 5; l++) begin
          int s, rem, idx, n, k;
          logic [7:0] hb, lb;
          logic [15:0] ex;
          s = (o*3 + l) % 11;
          m_tc = 32'h010001 + l;
          load_tc(m_tc);
          arm(o, s, l, 1);
          check("R1 drq", 32'(drq), 1);
          rem = l; idx = s; k = 0;
          while (rem > 0) begin
            n = (w == 1 && rem >= 2) ? 2 : 1;
            hb = 8'(o*61 + l*13 + k*7 + w);
            lb = hb ^ 8'hA5;
            access(1, w[0], {hb, lb}, rd);
            if (w == 1) begin
              model[o*DEPTH + idx] = hb;
              if (n == 2) model[o*DEPTH + (idx+1)%DEPTH] = lb;
            end else begin
              model[o*DEPTH + idx] = lb;
            end
            idx = (idx + n) % DEPTH; rem -= n; k++;
            m_tc = (m_tc > n) ? m_tc - n : 0;
            check("R6 tc after write", tc_now(), m_tc);
            check("R8 drq", 32'(drq), (rem > 0) ? 1 : 0);
            check("R8 done", 32'(done), (rem == 0) ? 1 : 0);
            if (rem == 0) check("R9 done_count", 32'(done_count), l);
          end
          @(negedge clk);
          check("R8 done one cycle", 32'(done), 0);
          for (int a = 0; a < DEPTH; a++) begin
            eng_read(o, a, b);
            check("R2 buffer contents", 32'(b), 32'(model[o*DEPTH + a]));
          end
          arm(o, s, l, 0);
          rem = l; idx = s;
          while (rem > 0) begin
            n = (w == 1 && rem >= 2) ? 2 : 1;
            if (w == 0) ex = {8'h00, model[o*DEPTH + idx]};
            else if (n == 2) ex = {model[o*DEPTH + idx], model[o*DEPTH + (idx+1)%DEPTH]};
            else ex = {model[o*DEPTH + idx], 8'h00};
            access(0, w[0], 16'h0, rd);
            if (w == 0) check("R4 byte read", 32'(rd), 32'(ex));
            else if (n == 2) check("R5 pair read", 32'(rd), 32'(ex));
            else check("R10 short pair read", 32'(rd), 32'(ex));
            idx = (idx + n) % DEPTH; rem -= n;
          end
          check("R6 reads keep tc", tc_now(), m_tc);
          check("R8 no notify drq", 32'(drq), 1);
          check("R8 no notify done", 32'(done), 0);
          access(0, w[0], 16'h0, rd);
          check("R7 empty read", 32'(rd), 0);
          check("R7 empty read drq", 32'(drq), 1);
        end
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule